// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable model of a synchronous static RAM. Reads and writes can follow each other on consecutive clocks with no idle cycle on the data bus. Each command is sampled on a rising clock edge. Its data moves exactly two enabled edges later. Read data is registered onto the bus after that edge, and write data is captured at that edge. The array is 36 bits wide, split into four 9-bit byte lanes. Its depth is set by the address width.

A command cycle either loads a new external address or advances an internal two-bit burst counter. A burst keeps the direction chosen by its load cycle. An active-low clock enable freezes the whole block for as long as it is high: pipeline, burst state, array and output registers. The bidirectional data bus is split into an input word, an output word and an output-enable flag.

Top module: `zt_sram`

## Requirements
- R1: The device counts as selected only when `selN0` is 0, `selN1` is 0 and `sel2` is 1. Any other combination on a load cycle (`advance`=0) is a deselect, and no transfer takes place.
- R2: A selected load cycle with `rdWr`=1 is a read. After the second enabled edge that follows the command edge, `dOe` is 1 and `dOut` holds the word stored at the loaded address.
- R3: A selected load cycle with `rdWr`=0 is a write. The bus word is captured at the second enabled edge after the command edge, and `dOe` is 0 for that data phase.
- R4: With `advance`=1 during an active burst, the low two address bits step by +1 modulo 4 from the previous burst address. The upper bits are held, `rdWr` is ignored, and the direction stays the one set by the load cycle.
- R5: With `advance`=1 when the previous command was a deselect (or when no burst has started since reset), the cycle is a no-op and leaves `dOe` at 0 two edges later.
- R6: After a deselect command edge, `dOe` is 0 following the second enabled edge.
- R7: While `clkEnN` is 1 at an edge, that edge has no effect. `dOut` and `dOe` stay unchanged, no pipeline or burst state moves, and the array is not written.
- R8: `laneWeN[n]` (active low), sampled at the write data phase, enables lane n. Lane n is data bits [8n+7:8n] plus parity bit 32+n of the bus. Several lanes may be written together. All four high writes nothing.
- R9: `laneWeN` has no effect on read transfers.
- R10: Following an edge with `rstN`=0, `dOe` is 0. After reset release, no burst is active.
- R11: Reads and writes may alternate on consecutive command cycles. A read issued the cycle after a write to the same address returns the newly written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| clkEnN | input | 1 | Clock enable, active low; high freezes the block |
| selN0 | input | 1 | Chip select, active low |
| selN1 | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| rdWr | input | 1 | 1 = read, 0 = write (load cycles only) |
| advance | input | 1 | 0 = load external address, 1 = advance burst |
| laneWeN | input | 4 | Per-lane write enables, active low, taken at the data phase |
| addr | input | ADDR_W | Word address, used on load cycles |
| dIn | input | 36 | Bus input: [31:0] data, [35:32] lane parity |
| dOut | output | 36 | Bus output word, same layout |
| dOe | output | 1 | Bus output enable; 0 means high-impedance |

## Verification
Every command result is due at the second enabled edge after its command edge. Read data and `dOe` can be checked after that edge, and write contents become visible through a later read. Edges where the clock enable is high do not count toward the two, and outputs must hold across them. The bench samples on the falling edge. It runs a reference pipeline that moves one step only on enabled edges, so each comparison lands on the cycle the requirement names. Byte enables and write data are supplied in the data-phase cycle rather than with the command.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;
  localparam int LANE_BITS = 8;
  localparam int LANES     = 4;
  localparam int LANE_W    = LANE_BITS + 1;
  localparam int BUS_W     = LANES * LANE_W;
  localparam int DATA_BITS = LANES * LANE_BITS;
  localparam int BURST_W   = 2;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } opE;

  // strobes from control to datapath for the data phase
  typedef struct packed {
    logic tick;
    logic doWrite;
    logic doRead;
  } strobeT;
endpackage

// File: rtl/zt_sram_ctrl.sv
module zt_sram_ctrl
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnN,
  input  logic              selN0,
  input  logic              selN1,
  input  logic              sel2,
  input  logic              rdWr,
  input  logic              advance,
  input  logic [ADDR_W-1:0] addr,
  output strobeT            stb,
  output logic [ADDR_W-1:0] dataAddr
);
  logic              selected;
  logic              burstOn;
  logic              burstRd;
  logic [ADDR_W-1:0] burstAddr;
  logic [ADDR_W-1:0] stepAddr;
  opE                cmdOp, s1Op, s2Op;
  logic [ADDR_W-1:0] cmdAddr, s1Addr, s2Addr;

  assign selected = !selN0 && !selN1 && sel2;
  assign stepAddr = {burstAddr[ADDR_W-1:BURST_W],
                     burstAddr[BURST_W-1:0] + BURST_W'(1)};

  // decode of the command presented this cycle
  always_comb begin
    cmdOp   = OP_NONE;
    cmdAddr = addr;
    if (!advance) begin
      if (selected) cmdOp = rdWr ? OP_READ : OP_WRITE;
    end else if (burstOn) begin
      cmdOp   = burstRd ? OP_READ : OP_WRITE;
      cmdAddr = stepAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      burstOn   <= 1'b0;
      burstRd   <= 1'b0;
      burstAddr <= '0;
      s1Op      <= OP_NONE;
      s2Op      <= OP_NONE;
      s1Addr    <= '0;
      s2Addr    <= '0;
    end else if (!clkEnN) begin
      if (!advance) begin
        burstOn <= selected;
        if (selected) begin
          burstRd   <= rdWr;
          burstAddr <= addr;
        end
      end else if (burstOn) begin
        burstAddr <= stepAddr;
      end
      s1Op   <= cmdOp;
      s1Addr <= cmdAddr;
      s2Op   <= s1Op;
      s2Addr <= s1Addr;
    end
  end

  always_comb begin
    stb.tick    = !clkEnN;
    stb.doWrite = (s2Op == OP_WRITE);
    stb.doRead  = (s2Op == OP_READ);
  end
  assign dataAddr = s2Addr;
endmodule

// File: rtl/zt_sram_dp.sv
module zt_sram_dp
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            stb,
  input  logic [ADDR_W-1:0] dataAddr,
  input  logic [LANES-1:0]  laneWeN,
  input  logic [BUS_W-1:0]  dIn,
  output logic [BUS_W-1:0]  dOut,
  output logic              dOe
);
  localparam int DEPTH = 1 << ADDR_W;

  wire [BUS_W-1:0] rdWord;

  for (genvar n = 0; n < LANES; n++) begin : g_lane
    logic [LANE_W-1:0] laneMem [DEPTH];
    wire  [LANE_W-1:0] wrLane = {dIn[DATA_BITS+n], dIn[n*LANE_BITS +: LANE_BITS]};
    wire  [LANE_W-1:0] rdLane = laneMem[dataAddr];

    always_ff @(posedge clk) begin
      if (stb.tick && stb.doWrite && !laneWeN[n]) laneMem[dataAddr] <= wrLane;
    end

    assign rdWord[n*LANE_BITS +: LANE_BITS] = rdLane[LANE_BITS-1:0];
    assign rdWord[DATA_BITS+n]              = rdLane[LANE_BITS];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dOe  <= 1'b0;
      dOut <= '0;
    end else if (stb.tick) begin
      dOe <= stb.doRead;
      if (stb.doRead) dOut <= rdWord;
    end
  end
endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnN,
  input  logic              selN0,
  input  logic              selN1,
  input  logic              sel2,
  input  logic              rdWr,
  input  logic              advance,
  input  logic [LANES-1:0]  laneWeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  dIn,
  output logic [BUS_W-1:0]  dOut,
  output logic              dOe
);
  strobeT            stb;
  logic [ADDR_W-1:0] dataAddr;

  zt_sram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN),
    .selN0(selN0), .selN1(selN1), .sel2(sel2),
    .rdWr(rdWr), .advance(advance), .addr(addr),
    .stb(stb), .dataAddr(dataAddr)
  );

  zt_sram_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .dataAddr(dataAddr),
    .laneWeN(laneWeN), .dIn(dIn), .dOut(dOut), .dOe(dOe)
  );
endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk
  import zt_sram_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             clkEnN,
  input logic             selN0,
  input logic             selN1,
  input logic             sel2,
  input logic             rdWr,
  input logic             advance,
  input logic [BUS_W-1:0] dOut,
  input logic             dOe
);
  // port-level shadow of load commands, moved only on enabled edges
  logic       pickedUp;
  logic [1:0] rdPipe, wrPipe, offPipe;

  assign pickedUp = !selN0 && !selN1 && sel2;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPipe  <= '0;
      wrPipe  <= '0;
      offPipe <= '0;
    end else if (!clkEnN) begin
      rdPipe  <= {rdPipe[0],  !advance && pickedUp && rdWr};
      wrPipe  <= {wrPipe[0],  !advance && pickedUp && !rdWr};
      offPipe <= {offPipe[0], !advance && !pickedUp};
    end
  end

  p_reset_hiz_r10: assert property (@(posedge clk) !rstN |=> !dOe);

  p_freeze_r7: assert property (@(posedge clk) disable iff (!rstN)
    clkEnN |=> ($stable(dOe) && $stable(dOut)));

  p_read_drives_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && rdPipe[1]) |=> dOe);

  p_write_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && wrPipe[1]) |=> !dOe);

  p_deselect_hiz_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && offPipe[1]) |=> !dOe);
endmodule

bind zt_sram zt_sram_chk u_chk (.*);

// File: tb/zt_sram_bench.sv
`timescale 1ns/1ps
module zt_sram_bench;
  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rstN, clkEnN, selN0, selN1, sel2, rdWr, advance;
  logic [3:0]    laneWeN;
  logic [AW-1:0] addr;
  logic [35:0]   dIn, dOut;
  logic          dOe;

  zt_sram #(.ADDR_W(AW)) u_zt_sram (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .selN0(selN0), .selN1(selN1),
    .sel2(sel2), .rdWr(rdWr), .advance(advance), .laneWeN(laneWeN),
    .addr(addr), .dIn(dIn), .dOut(dOut), .dOe(dOe)
  );

  int    checks = 0;
  int    errors = 0;
  string curReq = "R10";
  bit    live   = 0;

  // reference model: 0 none, 1 read, 2 write
  logic [35:0]   mMem [DEPTH];
  bit            bOn, bRd;
  logic [AW-1:0] bA, p1a, p2a;
  int            p1op, p2op;
  bit            expOe;
  logic [35:0]   expOut;

  task automatic chk(bit ok, string what, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", curReq, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] nextBurst(logic [AW-1:0] a);
    return {a[AW-1:2], a[1:0] + 2'd1};
  endfunction

  task automatic cyc(bit ce, bit s0, bit s1, bit s2, bit rw, bit adv,
                     logic [3:0] bwe, logic [AW-1:0] a);
    int cop;
    logic [AW-1:0] ca;
    @(negedge clk);
    if (live) begin
      chk(dOe === expOe, "dOe", {35'd0, dOe}, {35'd0, expOe});
      if (expOe) chk(dOut === expOut, "dOut", dOut, expOut);
    end
    clkEnN = ce; selN0 = s0; selN1 = s1; sel2 = s2;
    rdWr = rw; advance = adv; laneWeN = bwe; addr = a;
    dIn = {4'($urandom), 32'($urandom)};
    if (!ce) begin
      if (p2op == 2)
        for (int n = 0; n < 4; n++)
          if (!bwe[n]) begin
            mMem[p2a][8*n +: 8] = dIn[8*n +: 8];
            mMem[p2a][32+n]     = dIn[32+n];
          end
      expOe = (p2op == 1);
      if (p2op == 1) expOut = mMem[p2a];
      cop = 0; ca = a;
      if (!adv) begin
        if (!s0 && !s1 && s2) begin
          cop = rw ? 1 : 2; bOn = 1; bRd = rw; bA = a;
        end else bOn = 0;
      end else if (bOn) begin
        bA = nextBurst(bA); cop = bRd ? 1 : 2; ca = bA;
      end
      p2op = p1op; p2a = p1a; p1op = cop; p1a = ca;
    end
  endtask

  task automatic desel();
    cyc(0, 1, 0, 1, 0, 0, 4'hF, '0);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired during %s", curReq);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd7021));
    rstN = 0; clkEnN = 0; selN0 = 1; selN1 = 1; sel2 = 0; rdWr = 0;
    advance = 0; laneWeN = 4'hF; addr = '0; dIn = '0;
    bOn = 0; bRd = 0; bA = '0; p1a = '0; p2a = '0; p1op = 0; p2op = 0;
    expOe = 0; expOut = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    curReq = "R10";
    chk(dOe === 1'b0, "dOe in reset", {35'd0, dOe}, 36'd0);
    rstN = 1; live = 1;

    // fill whole array with full-width burst writes starting at each offset
    curReq = "R4";
    for (int b = 0; b < DEPTH / 4; b++) begin
      cyc(0, 0, 0, 1, 0, 0, 4'h0, AW'(b * 4 + (b % 4)));
      for (int k = 0; k < 3; k++) cyc(0, 0, 0, 1, 1'($urandom), 1, 4'h0, AW'($urandom));
    end
    desel(); desel();

    // read burst wrapping from offset 2, rdWr toggled (ignored) and byte enables random
    curReq = "R9";
    cyc(0, 0, 0, 1, 1, 0, 4'($urandom), 6'h0E);
    for (int k = 0; k < 3; k++) cyc(0, 0, 0, 1, 0, 1, 4'($urandom), AW'($urandom));
    curReq = "R6";
    desel(); desel(); desel();

    curReq = "R5";
    for (int k = 0; k < 4; k++) cyc(0, 0, 0, 1, 1'($urandom), 1, 4'h0, AW'($urandom));

    curReq = "R1";
    for (int c = 0; c < 8; c++) begin
      cyc(0, c[0], c[1], c[2], 1, 0, 4'h0, AW'(c));
      desel();
    end
    desel(); desel();

    curReq = "R7";
    cyc(0, 0, 0, 1, 1, 0, 4'h0, 6'h11);
    cyc(0, 0, 0, 1, 0, 0, 4'h0, 6'h12);
    for (int k = 0; k < 3; k++) cyc(1, 0, 0, 1, 1, 0, 4'h0, AW'($urandom));
    cyc(0, 1, 1, 0, 0, 0, 4'h0, '0);
    for (int k = 0; k < 3; k++) cyc(1, 0, 0, 1, 0, 0, 4'h0, AW'($urandom));
    desel(); desel();
    cyc(0, 0, 0, 1, 1, 0, 4'h0, 6'h12);
    desel(); desel(); desel();

    curReq = "R8";
    cyc(0, 0, 0, 1, 0, 0, 4'hF, 6'h05);
    desel();
    cyc(0, 1, 0, 1, 0, 0, 4'b1010, '0);
    cyc(0, 0, 0, 1, 0, 0, 4'h0, 6'h06);
    desel();
    cyc(0, 1, 0, 1, 0, 0, 4'hF, '0);
    cyc(0, 0, 0, 1, 1, 0, 4'h0, 6'h05);
    cyc(0, 0, 0, 1, 1, 0, 4'h0, 6'h06);
    desel(); desel(); desel();

    curReq = "R11";
    for (int k = 0; k < 6; k++) begin
      cyc(0, 0, 0, 1, 0, 0, 4'h0, AW'(k + 20));
      cyc(0, 0, 0, 1, 1, 0, 4'h0, AW'(k + 20));
    end
    desel(); desel(); desel();

    curReq = "R2 R3";
    for (int i = 0; i < 4000; i++) begin
      bit ce;
      logic [2:0] en;
      ce = ($urandom % 8 == 0);
      en = ($urandom % 6 == 0) ? 3'($urandom) : 3'b100;
      cyc(ce, en[0], en[1], en[2], 1'($urandom), 1'($urandom),
          ($urandom % 3 == 0) ? 4'($urandom) : 4'h0, AW'($urandom));
    end
    desel(); desel(); desel();

    summary();
    $finish;
  end
endmodule